// File: doc/BRIEF.md
# Clock Manager Auto-Relock Supervisor

An on-chip clock manager (a PLL or DLL style block) only acquires lock if it is reset while its input clock is valid. When that input clock starts at an unusable frequency and becomes valid at some unknown later time, the manager needs another reset before it will lock. This supervisor issues those resets by itself. It samples the manager's locked output and its two stopped-clock flags. At every check point where the manager is unhealthy, it sends a one-cycle reset and then waits a settling interval before it looks again.

Automatic operation is gated by an enable input, which the integrating design ties low by default. With the enable low, the manager reset is a registered copy of the user's reset request. With the enable high, the block runs its sequence: one initial pulse, a settling wait, then a repeating check. At each check it either pulses and waits again or only waits again. A user reset request at any time restarts the sequence. A sticky flag records that the supervisor has had to retry, so a fault can be traced afterwards.

The wait length is set in supervisor cycles by the product of two parameters, the assumed clock rate in MHz and the settle time in microseconds. A third parameter decides whether the synthesized-clock-stopped flag counts as a fault.

Top module: `clkmgr_relock_sup`

## Requirements
- R1: When the enable is high and the user request is low, the first clock edge after global reset, or after the enable rises, produces one initial manager reset pulse. The pulse is visible on `mgr_rst` right after that edge. This initial pulse does not set `relock_seen`.
- R2: In automatic mode every reset pulse the supervisor issues by itself is exactly one supervisor clock cycle wide.
- R3: The settle interval is W = REF_CLK_MHZ × SETTLE_US cycles. While a fault persists, consecutive automatic pulses start W+2 cycles apart: one pulse cycle, W wait cycles and one check cycle.
- R4: At a check, the block pulses `mgr_rst` on the next cycle if the synchronized `mgr_in_stopped` is high, or if the synchronized `mgr_syn_stopped` is high and USE_SYN_STOP is 1. This holds even while locked is high.
- R5: When a check finds locked high and no stopped flag, no pulse is issued, and the next check follows W+1 cycles later.
- R6: The status inputs reach the checker through a two-flop synchronizer. A stopped flag that is high for one cycle during a wait and low again well before the check causes no pulse.
- R7: With `auto_en` low, `mgr_rst` equals `user_rst_req` delayed by one cycle. No automatic pulse is issued, whatever the status inputs do.
- R8: `relock_seen` rises in the same cycle as the first pulse caused by a failed check, and then stays high. It goes low only on global reset or on the cycle after a sampled user request.
- R9: With USE_SYN_STOP = 0, `mgr_syn_stopped` has no effect on `mgr_rst`.
- R10: In automatic mode a user request drives `mgr_rst` high one cycle later, for as many cycles as the request was held. It aborts any wait in progress, and the next check comes W+1 cycles after the last request-driven pulse.
- R11: During and right after global reset with the enable low, `mgr_rst` and `relock_seen` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Supervisor clock from a free-running source |
| rst | input | 1 | Synchronous active-high global reset |
| auto_en | input | 1 | Enables automatic relocking; low gives plain pass-through mode |
| user_rst_req | input | 1 | User request to reset the clock manager |
| mgr_locked | input | 1 | Locked indication from the clock manager (asynchronous) |
| mgr_in_stopped | input | 1 | Manager reports that its input clock has stopped (asynchronous) |
| mgr_syn_stopped | input | 1 | Manager reports that its synthesized output has stopped (asynchronous) |
| mgr_rst | output | 1 | Registered reset to the clock manager |
| relock_seen | output | 1 | Sticky flag: the supervisor has retried after a failed check |

## Verification
The bench drives a manager model that locks only after a reset taken while its source is valid. It switches that source from bad to good at a time that falls between retries. A design with the wrong interval would place its pulses off the predicted cycles. A design that skipped retrying would never lock and would stall the expected sequence. Stopped flags are raised while locked is high, with their timing set against the synchronizer delay. A one-cycle blip checks that a design sampling raw inputs would pulse too often. A second instance with the synthesizer flag masked must stay quiet. A user request in the middle of a wait must restart the schedule: a design that did not abort would pulse on the old phase. That request must also clear the sticky flag, while the initial pulse must not set it.

// File: rtl/relock_pkg.sv
package relock_pkg;

  typedef enum logic [1:0] {
    ST_START = 2'd0,
    ST_PULSE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_CHECK = 2'd3
  } sup_state_t;

  localparam int STATUS_W = 3;

  typedef struct packed {
    logic locked;
    logic in_stop;
    logic syn_stop;
  } mgr_status_t;

endpackage

// File: rtl/relock_sync.sv
module relock_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg <= '0;
    end else begin
      for (int i = STAGES - 1; i > 0; i--) begin
        stg[i] <= stg[i-1];
      end
      stg[0] <= d;
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/relock_timer.sv
module relock_timer #(
  parameter int CYCLES = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic done
);
  localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CW-1:0] RELOAD = CW'(CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= RELOAD;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/relock_fsm.sv
module relock_fsm
  import relock_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic auto_en,
  input  logic user_req,
  input  logic fault,
  input  logic tmr_done,
  output logic tmr_load,
  output logic retry,
  output logic mgr_rst
);
  sup_state_t st, nxt;

  always_comb begin
    nxt      = st;
    tmr_load = 1'b0;
    retry    = 1'b0;
    if (!auto_en) begin
      nxt = ST_START;
    end else if (user_req) begin
      nxt = ST_PULSE;
    end else begin
      case (st)
        ST_START: nxt = ST_PULSE;
        ST_PULSE: begin
          nxt      = ST_WAIT;
          tmr_load = 1'b1;
        end
        ST_WAIT:  if (tmr_done) nxt = ST_CHECK;
        ST_CHECK: begin
          if (fault) begin
            nxt   = ST_PULSE;
            retry = 1'b1;
          end else begin
            nxt      = ST_WAIT;
            tmr_load = 1'b1;
          end
        end
        default:  nxt = ST_START;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_START;
      mgr_rst <= 1'b0;
    end else begin
      st      <= nxt;
      mgr_rst <= auto_en ? (nxt == ST_PULSE) : user_req;
    end
  end

  assert_single_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    (mgr_rst && $past(auto_en) && auto_en && !user_req) |=> !mgr_rst);

  assert_follow_user_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(auto_en)) |-> (mgr_rst == $past(user_req)));

  assert_check_after_wait_R5: assert property (@(posedge clk) disable iff (rst)
    (st == ST_CHECK) |-> ($past(st) == ST_WAIT));

  assert_fault_retries_R4: assert property (@(posedge clk) disable iff (rst)
    (st == ST_CHECK && fault && auto_en && !user_req) |=> (mgr_rst && st == ST_PULSE));
endmodule

// File: rtl/relock_sticky.sv
module relock_sticky (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic seen
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      seen <= 1'b0;
    end else if (set) begin
      seen <= 1'b1;
    end
  end

  assert_sticky_clear_R8: assert property (@(posedge clk) disable iff (rst)
    $past(clr) |-> !seen);

  assert_sticky_hold_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(seen) |-> $past(clr));
endmodule

// File: rtl/clkmgr_relock_sup.sv
module clkmgr_relock_sup
  import relock_pkg::*;
#(
  parameter int REF_CLK_MHZ  = 25,
  parameter int SETTLE_US    = 4,
  parameter int USE_SYN_STOP = 1,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic auto_en,
  input  logic user_rst_req,
  input  logic mgr_locked,
  input  logic mgr_in_stopped,
  input  logic mgr_syn_stopped,
  output logic mgr_rst,
  output logic relock_seen
);
  localparam int   WAIT_CYCLES = REF_CLK_MHZ * SETTLE_US;
  localparam logic SYN_MASK    = (USE_SYN_STOP != 0);

  logic [STATUS_W-1:0] raw_status, sync_status;
  mgr_status_t         status_s;
  logic                fault, tmr_load, tmr_done, retry;

  assign raw_status = {mgr_locked, mgr_in_stopped, mgr_syn_stopped};
  assign status_s   = mgr_status_t'(sync_status);
  assign fault      = !status_s.locked | status_s.in_stop | (status_s.syn_stop & SYN_MASK);

  relock_sync #(.WIDTH(STATUS_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw_status),
    .q   (sync_status)
  );

  relock_timer #(.CYCLES(WAIT_CYCLES)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .load (tmr_load),
    .done (tmr_done)
  );

  relock_fsm u_fsm (
    .clk      (clk),
    .rst      (rst),
    .auto_en  (auto_en),
    .user_req (user_rst_req),
    .fault    (fault),
    .tmr_done (tmr_done),
    .tmr_load (tmr_load),
    .retry    (retry),
    .mgr_rst  (mgr_rst)
  );

  relock_sticky u_sticky (
    .clk  (clk),
    .rst  (rst),
    .set  (retry),
    .clr  (user_rst_req),
    .seen (relock_seen)
  );
endmodule

// File: tb/clkmgr_relock_sup_tb.sv
module clkmgr_relock_sup_tb;
  logic clk = 1'b0, rst = 1'b1, auto_en = 1'b0, user_req = 1'b0;
  logic in_stop = 1'b0, syn_stop = 1'b0, src_good = 1'b0;
  logic mgr_rst, seen, mgr_rst_ns, seen_ns;
  logic armed = 1'b0, mdl_locked = 1'b0;
  int   lk_cnt = 0;
  int   cyc = 0, n_chk = 0, n_fail = 0;
  bit   done = 1'b0;
  int    exp_cyc[$];
  string exp_tag[$];
  bit   ns_win = 1'b0;
  int   ns_pulses = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  clkmgr_relock_sup #(.REF_CLK_MHZ(5), .SETTLE_US(2), .USE_SYN_STOP(1)) u_dut (
    .clk(clk), .rst(rst), .auto_en(auto_en), .user_rst_req(user_req),
    .mgr_locked(mdl_locked), .mgr_in_stopped(in_stop), .mgr_syn_stopped(syn_stop),
    .mgr_rst(mgr_rst), .relock_seen(seen));

  clkmgr_relock_sup #(.REF_CLK_MHZ(5), .SETTLE_US(2), .USE_SYN_STOP(0)) u_dut_ns (
    .clk(clk), .rst(rst), .auto_en(auto_en), .user_rst_req(user_req),
    .mgr_locked(mdl_locked), .mgr_in_stopped(in_stop), .mgr_syn_stopped(syn_stop),
    .mgr_rst(mgr_rst_ns), .relock_seen(seen_ns));

  // clock manager model: locks only after a reset taken while the source is valid
  always @(posedge clk) begin
    if (mgr_rst) begin
      armed <= src_good; lk_cnt <= 0; mdl_locked <= 1'b0;
    end else if (!src_good) begin
      armed <= 1'b0; lk_cnt <= 0; mdl_locked <= 1'b0;
    end else if (armed) begin
      if (lk_cnt < 3) lk_cnt <= lk_cnt + 1;
      else mdl_locked <= 1'b1;
    end
  end

  task automatic chk(string tag, int act, int expv);
    n_chk++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, expv, cyc);
    end
  endtask

  task automatic expect_pulse(int at, string tag);
    exp_cyc.push_back(at);
    exp_tag.push_back(tag);
  endtask

  task automatic goto(int n);
    while (cyc < n) @(negedge clk);
  endtask

  // scoreboard monitor: every high sample of mgr_rst must match the next expected cycle
  always @(negedge clk) begin : monitor
    int e;
    string t;
    if (mgr_rst) begin
      n_chk++;
      if (exp_cyc.size() == 0) begin
        n_fail++;
        $display("FAIL R2/R3: unexpected mgr_rst at actual cycle %0d expected none", cyc);
      end else begin
        e = exp_cyc.pop_front();
        t = exp_tag.pop_front();
        if (e != cyc) begin
          n_fail++;
          $display("FAIL %s: mgr_rst at actual cycle %0d expected cycle %0d", t, cyc, e);
        end
      end
    end
    if (ns_win && mgr_rst_ns) ns_pulses++;
  end

  initial begin : main
    // R11 reset state
    goto(5);
    chk("R11 mgr_rst in reset", int'(mgr_rst), 0);
    chk("R11 relock_seen in reset", int'(seen), 0);
    rst = 1'b0;
    // R7 pass-through mode
    goto(8);  user_req = 1'b1; expect_pulse(9, "R7");
    goto(9);  user_req = 1'b0;
    goto(12); user_req = 1'b1;
    expect_pulse(13, "R7"); expect_pulse(14, "R7"); expect_pulse(15, "R7");
    goto(15); user_req = 1'b0;
    goto(16); in_stop = 1'b1;
    goto(20); in_stop = 1'b0;
    chk("R7 no sticky when disabled", int'(seen), 0);
    // R1 initial pulse, R3 retries every W+2
    goto(25); auto_en = 1'b1;
    expect_pulse(26, "R1"); expect_pulse(38, "R3");
    expect_pulse(50, "R3"); expect_pulse(62, "R3");
    goto(37); chk("R8 initial pulse leaves sticky low", int'(seen), 0);
    goto(38); chk("R8 sticky set with first retry", int'(seen), 1);
    goto(55); src_good = 1'b1;
    // R6 single-cycle blip ignored
    goto(76); in_stop = 1'b1;
    goto(77); in_stop = 1'b0;
    goto(100); chk("R5 manager locked", int'(mdl_locked), 1);
    // R4 input-clock-stopped while locked
    goto(101); in_stop = 1'b1; expect_pulse(107, "R4");
    goto(108); in_stop = 1'b0;
    chk("R8 sticky stays high", int'(seen), 1);
    // R4/R9 synthesized-clock-stopped
    goto(135); syn_stop = 1'b1; ns_win = 1'b1; expect_pulse(141, "R4");
    goto(142); syn_stop = 1'b0;
    goto(152); ns_win = 1'b0;
    chk("R9 masked flag gives no pulse", ns_pulses, 0);
    // R10 user request aborts wait
    goto(158); user_req = 1'b1; expect_pulse(159, "R10");
    goto(159); user_req = 1'b0;
    chk("R8 sticky cleared by request", int'(seen), 0);
    goto(160); src_good = 1'b0;
    expect_pulse(171, "R10");
    goto(170); chk("R8 sticky low before retry", int'(seen), 0);
    goto(171); chk("R10 sticky set on restarted retry", int'(seen), 1);
    goto(172); src_good = 1'b1;
    expect_pulse(183, "R3");
    goto(230);
    chk("R5 relocked after source recovers", int'(mdl_locked), 1);
    auto_en = 1'b0;
    goto(231); rst = 1'b1;
    goto(233);
    chk("R11 sticky cleared by reset", int'(seen), 0);
    chk("R11 mgr_rst low in reset", int'(mgr_rst), 0);
    chk("R3 all expected pulses seen", exp_cyc.size(), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule